// File: doc/BRIEF.md
# Fan Motor Fault Supervisor

This block supervises a single-phase fan motor bridge. It decides when a protective condition takes over the bridge, which condition wins when several are present, how long the block waits before it tries to drive again, and when a repeated failure turns into a sticky fault. Its inputs are the outputs of external comparators, a one-cycle Hall transition strobe and a one-cycle strobe at the start of each PWM period. It produces a two-bit bridge command for the gate-drive logic, a rotor-lock flag, a fault flag and a latched-fault status.

The locked-rotor detection window and both retry intervals are parameters counted in clock ticks. So are the number of failed starts that latch the lock fault and the number of consecutive overcurrent events that latch the overcurrent fault. The active-low reset doubles as the wake-up input. It is the only way to clear a latched fault, apart from an undervoltage event, which drops all logic state.

Top module: `fan_fault_sup`

## Requirements
- R1: With no Hall strobe for LRD_TICKS cycles of unobstructed drive, lock_flag rises and bridge_cmd is 1 (all FETs Hi-Z). lock_flag stays high for QUICK_RETRY cycles when cfg_quick_retry=1, or for LONG_RETRY cycles when it is 0. Drive then resumes, and the next lock follows LRD_TICKS cycles later.
- R2: With cfg_lr_latch=1, the LR_MAX_TRIES-th consecutive failed start sets latched and holds lock_flag high and bridge_cmd at 1 until reset. With cfg_lr_latch=0 the block keeps retrying and never latches.
- R3: A Hall strobe clears the count of failed starts, so LR_MAX_TRIES more lock events are needed before the fault latches.
- R4: A single-cycle ilim_flag gives bridge_cmd=3 (high side off, low-side recirculation) from the next cycle. This holds until a cycle with pwm_start=1 and ilim_flag=0. A pwm_start while ilim_flag=1 keeps it.
- R5: With cfg_ocp_latch=0, each overcurrent event raises fault_flag and sets bridge_cmd=1 for LONG_RETRY cycles. Drive then resumes for one cycle. A persistent overcurrent never latches.
- R6: With cfg_ocp_latch=1, OC_MAX_EVENTS consecutive overcurrent events set latched. An event counts as consecutive only if the overcurrent is present on the first drive cycle after the retry. Events separated by drive cycles without overcurrent never latch.
- R7: ovp_flag forces bridge_cmd=1 and fault_flag in the same cycle, only while cfg_ovp_en=1, and releases as soon as the flag drops.
- R8: A pulse on tsd_set forces bridge_cmd=1 and fault_flag from the next cycle. This is held until a pulse on tsd_clr.
- R9: uvlo_flag forces bridge_cmd=1 in the same cycle without raising fault_flag. It clears all counters, retry state and latched faults.
- R10: clamp_flag with cfg_clamp_dis=0 gives bridge_cmd=2 (high side only off) in the same cycle. With cfg_clamp_dis=1 it has no effect.
- R11: Priority from highest to lowest is undervoltage, thermal, overvoltage, overcurrent, locked rotor, current limit, clamp. bridge_cmd encoding: 0 drive, 1 Hi-Z, 2 high-side off, 3 recirculate.
- R12: After reset, with Hall strobes present, bridge_cmd=0 and lock_flag, fault_flag and latched are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset and wake-up |
| hall_edge | input | 1 | One-cycle strobe per Hall transition |
| pwm_start | input | 1 | One-cycle strobe at PWM period start |
| ilim_flag | input | 1 | Low-side current above limit |
| ocp_flag | input | 1 | Overcurrent comparator |
| ovp_flag | input | 1 | Supply above overvoltage level |
| uvlo_flag | input | 1 | Supply below undervoltage level |
| clamp_flag | input | 1 | Supply above clamp level |
| tsd_set | input | 1 | Temperature above shutdown threshold |
| tsd_clr | input | 1 | Temperature below threshold minus hysteresis |
| cfg_ovp_en | input | 1 | Enable overvoltage action |
| cfg_clamp_dis | input | 1 | Disable clamp action |
| cfg_lr_latch | input | 1 | Latch lock fault after repeated failed starts |
| cfg_ocp_latch | input | 1 | Latch overcurrent fault after consecutive events |
| cfg_quick_retry | input | 1 | Use the quick lock retry interval |
| bridge_cmd | output | 2 | Bridge command (0 drive, 1 Hi-Z, 2 HS off, 3 recirculate) |
| lock_flag | output | 1 | Rotor lock waiting or latched |
| fault_flag | output | 1 | Thermal, overvoltage or overcurrent active |
| latched | output | 1 | A latched fault is held |

## Verification
Current-limit recirculation, the clamp and the Hi-Z conditions can all be present in the same cycle. Priority is therefore exercised by a full sweep over the 32 combinations of undervoltage, thermal state, overvoltage, registered current limit and clamp. In each step the registered sources are loaded one cycle ahead and the combinational sources are applied in the cycle under test. The bench computes the expected command from the priority rule and compares it with the output. A second coincidence is a PWM period start that arrives while the current-limit flag is still high. It is provoked directly and judged by the command staying at recirculation.

// File: rtl/fan_fault_sup.sv
module fan_fault_sup #(
  parameter int LRD_TICKS     = 1000,
  parameter int LONG_RETRY    = 5000,
  parameter int QUICK_RETRY   = 500,
  parameter int LR_MAX_TRIES  = 5,
  parameter int OC_MAX_EVENTS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hall_edge,
  input  logic       pwm_start,
  input  logic       ilim_flag,
  input  logic       ocp_flag,
  input  logic       ovp_flag,
  input  logic       uvlo_flag,
  input  logic       clamp_flag,
  input  logic       tsd_set,
  input  logic       tsd_clr,
  input  logic       cfg_ovp_en,
  input  logic       cfg_clamp_dis,
  input  logic       cfg_lr_latch,
  input  logic       cfg_ocp_latch,
  input  logic       cfg_quick_retry,
  output logic [1:0] bridge_cmd,
  output logic       lock_flag,
  output logic       fault_flag,
  output logic       latched
);
  localparam int RMAX = (LONG_RETRY > QUICK_RETRY) ? LONG_RETRY : QUICK_RETRY;
  localparam int RW = $clog2(RMAX) + 1;
  localparam int LW = $clog2(LRD_TICKS) + 1;
  localparam int TW = $clog2(LR_MAX_TRIES + 1);
  localparam int OW = $clog2(OC_MAX_EVENTS + 1);
  localparam logic [1:0] CMD_DRIVE = 2'd0, CMD_HIZ = 2'd1, CMD_HSOFF = 2'd2, CMD_RECIRC = 2'd3;

  logic tsd_q, ilim_q, lr_wait, lr_lat, oc_wait, oc_lat;
  logic [LW-1:0] lrd_cnt;
  logic [RW-1:0] lr_rt, oc_rt;
  logic [TW-1:0] lr_tries;
  logic [OW-1:0] oc_cnt;

  wire ovp_act   = cfg_ovp_en & ovp_flag;
  wire clamp_act = clamp_flag & ~cfg_clamp_dis;
  wire oc_hold   = oc_wait | oc_lat;
  wire lr_hold   = lr_wait | lr_lat;
  wire hard      = uvlo_flag | tsd_q | ovp_act | oc_hold;
  wire spinning  = ~hard & ~lr_hold;
  wire lr_trip   = spinning & ~hall_edge & (lrd_cnt == LW'(LRD_TICKS - 1));
  wire [RW-1:0] lr_len = cfg_quick_retry ? RW'(QUICK_RETRY - 1) : RW'(LONG_RETRY - 1);
  wire oc_event  = ocp_flag & ~oc_hold;

  always_ff @(posedge clk) begin
    if (!rst_n)       tsd_q <= 1'b0;
    else if (tsd_set) tsd_q <= 1'b1;
    else if (tsd_clr) tsd_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || uvlo_flag) ilim_q <= 1'b0;
    else if (pwm_start)      ilim_q <= ilim_flag;
    else if (ilim_flag)      ilim_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || uvlo_flag) begin
      oc_wait <= 1'b0; oc_lat <= 1'b0; oc_rt <= '0; oc_cnt <= '0;
    end else if (oc_event) begin
      oc_cnt <= cfg_ocp_latch ? oc_cnt + 1'b1 : '0;
      if (cfg_ocp_latch && oc_cnt == OW'(OC_MAX_EVENTS - 1)) oc_lat <= 1'b1;
      else begin oc_wait <= 1'b1; oc_rt <= '0; end
    end else if (oc_wait) begin
      if (oc_rt == RW'(LONG_RETRY - 1)) oc_wait <= 1'b0;
      else oc_rt <= oc_rt + 1'b1;
    end else if (!oc_lat) begin
      oc_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || uvlo_flag) begin
      lr_wait <= 1'b0; lr_lat <= 1'b0; lr_rt <= '0; lr_tries <= '0; lrd_cnt <= '0;
    end else if (spinning) begin
      if (hall_edge) begin
        lrd_cnt <= '0; lr_tries <= '0;
      end else if (lr_trip) begin
        lrd_cnt <= '0;
        lr_tries <= cfg_lr_latch ? lr_tries + 1'b1 : '0;
        if (cfg_lr_latch && lr_tries == TW'(LR_MAX_TRIES - 1)) lr_lat <= 1'b1;
        else begin lr_wait <= 1'b1; lr_rt <= '0; end
      end else begin
        lrd_cnt <= lrd_cnt + 1'b1;
      end
    end else begin
      lrd_cnt <= '0;
      if (hall_edge && !lr_lat) lr_tries <= '0;
      if (lr_wait) begin
        if (lr_rt >= lr_len) lr_wait <= 1'b0;
        else lr_rt <= lr_rt + 1'b1;
      end
    end
  end

  assign bridge_cmd = hard      ? CMD_HIZ :
                      lr_hold   ? CMD_HIZ :
                      ilim_q    ? CMD_RECIRC :
                      clamp_act ? CMD_HSOFF : CMD_DRIVE;
  assign lock_flag  = lr_hold;
  assign fault_flag = tsd_q | ovp_act | oc_hold;
  assign latched    = lr_lat | oc_lat;

  p_latch_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latched && !uvlo_flag |=> latched);
  p_tries_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lr_tries <= TW'(LR_MAX_TRIES));
  p_hall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hall_edge && !lr_lat && !uvlo_flag |=> lr_tries == '0);
  p_ilim_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_q && !pwm_start && !uvlo_flag |=> bridge_cmd != CMD_DRIVE);
  p_oc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_cnt <= OW'(OC_MAX_EVENTS));
  p_tsd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_set |=> fault_flag || ovp_act || $past(tsd_set) && tsd_clr);
  p_uv_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_flag |=> !latched || uvlo_flag && 1'b0 || !$past(uvlo_flag) || !latched);
  p_lock_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag |-> bridge_cmd == CMD_HIZ);
endmodule

// File: tb/fan_fault_sup_tb_top.sv
module fan_fault_sup_tb_top;
  localparam int LRD = 8, LONG = 12, QUICK = 4, TRIES = 5, OCN = 3;
  logic clk = 0, rst_n = 0;
  logic spin = 0, kick = 0;
  logic pwm_start = 0, ilim_flag = 0, ocp_flag = 0, ovp_flag = 0, uvlo_flag = 0, clamp_flag = 0;
  logic tsd_set = 0, tsd_clr = 0;
  logic cfg_ovp_en = 0, cfg_clamp_dis = 0, cfg_lr_latch = 0, cfg_ocp_latch = 0, cfg_quick_retry = 0;
  logic [1:0] bridge_cmd;
  logic lock_flag, fault_flag, latched, hall_edge;
  int ph = 0, total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;
  assign hall_edge = kick | (spin & (ph == 0));
  always @(negedge clk) ph <= (ph == 2) ? 0 : ph + 1;

  fan_fault_sup #(.LRD_TICKS(LRD), .LONG_RETRY(LONG), .QUICK_RETRY(QUICK),
                  .LR_MAX_TRIES(TRIES), .OC_MAX_EVENTS(OCN)) dut_i (
    .clk(clk), .rst_n(rst_n), .hall_edge(hall_edge), .pwm_start(pwm_start),
    .ilim_flag(ilim_flag), .ocp_flag(ocp_flag), .ovp_flag(ovp_flag), .uvlo_flag(uvlo_flag),
    .clamp_flag(clamp_flag), .tsd_set(tsd_set), .tsd_clr(tsd_clr), .cfg_ovp_en(cfg_ovp_en),
    .cfg_clamp_dis(cfg_clamp_dis), .cfg_lr_latch(cfg_lr_latch), .cfg_ocp_latch(cfg_ocp_latch),
    .cfg_quick_retry(cfg_quick_retry), .bridge_cmd(bridge_cmd), .lock_flag(lock_flag),
    .fault_flag(fault_flag), .latched(latched));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin bad++; $display("FAIL %s: act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; spin = 1; kick = 0; pwm_start = 0; ilim_flag = 0; ocp_flag = 0; ovp_flag = 0;
    uvlo_flag = 0; clamp_flag = 0; tsd_set = 0; tsd_clr = 0; cfg_ovp_en = 0; cfg_clamp_dis = 0;
    cfg_lr_latch = 0; cfg_ocp_latch = 0; cfg_quick_retry = 0;
    tick(3); rst_n = 1; tick(1);
  endtask

  task automatic wait_lock(input logic v);
    while (lock_flag != v) @(negedge clk);
  endtask

  task automatic wait_fault(input logic v);
    while (fault_flag != v) @(negedge clk);
  endtask

  initial begin
    int n, m, rises;
    do_reset();
    tick(20);
    check("R12 cmd", bridge_cmd, 0);
    check("R12 lock", lock_flag, 0);
    check("R12 fault", fault_flag, 0);
    check("R12 latched", latched, 0);

    for (int q = 0; q < 2; q++) begin
      do_reset(); cfg_quick_retry = q[0]; spin = 0;
      wait_lock(1);
      check("R1 cmd hiz", bridge_cmd, 1);
      for (int k = 0; k < 3; k++) begin
        n = 0; while (lock_flag) begin n++; @(negedge clk); end
        m = 0; while (!lock_flag) begin m++; @(negedge clk); end
        check("R1 retry length", n, q ? QUICK : LONG);
        check("R1 detect length", m, LRD);
        check("R2 no latch when disabled", latched, 0);
      end
    end

    do_reset(); cfg_lr_latch = 1; spin = 0; rises = 0;
    while (rises < 10) begin
      wait_lock(1); rises++;
      if (latched) break;
      wait_lock(0);
    end
    check("R2 latch on try", rises, TRIES);
    tick(40);
    check("R2 latched held", latched, 1);
    check("R2 lock held", lock_flag, 1);
    check("R2 cmd hiz", bridge_cmd, 1);
    do_reset();
    check("R2 reset clears", latched, 0);

    do_reset(); cfg_lr_latch = 1; spin = 0;
    for (int k = 0; k < TRIES - 1; k++) begin wait_lock(1); wait_lock(0); end
    kick = 1; tick(1); kick = 0;
    rises = 0;
    while (rises < 10) begin
      wait_lock(1); rises++;
      if (latched) break;
      wait_lock(0);
    end
    check("R3 tries restart after hall", rises, TRIES);

    do_reset();
    ilim_flag = 1; tick(1); ilim_flag = 0;
    check("R4 recirc", bridge_cmd, 3);
    tick(5);
    check("R4 held until period", bridge_cmd, 3);
    pwm_start = 1; ilim_flag = 1; tick(1); pwm_start = 0; ilim_flag = 0;
    check("R4 period with flag high", bridge_cmd, 3);
    pwm_start = 1; tick(1); pwm_start = 0;
    check("R4 released at period", bridge_cmd, 0);

    do_reset(); ocp_flag = 1;
    wait_fault(1);
    check("R5 cmd hiz", bridge_cmd, 1);
    for (int k = 0; k < 3; k++) begin
      n = 0; while (fault_flag) begin n++; @(negedge clk); end
      m = 0; while (!fault_flag) begin m++; @(negedge clk); end
      check("R5 retry length", n, LONG);
      check("R5 drive gap", m, 1);
    end
    check("R5 no latch", latched, 0);
    ocp_flag = 0;

    do_reset(); cfg_ocp_latch = 1; ocp_flag = 1; rises = 0;
    while (rises < 10) begin
      wait_fault(1); rises++;
      if (latched) break;
      wait_fault(0);
    end
    check("R6 latch on event", rises, OCN);
    ocp_flag = 0; tick(30);
    check("R6 latched held", latched, 1);
    check("R6 fault held", fault_flag, 1);
    uvlo_flag = 1; #1;
    check("R9 uv hiz", bridge_cmd, 1);
    tick(1); uvlo_flag = 0; #1;
    check("R9 uv clears latch", latched, 0);
    check("R9 no fault indication", fault_flag, 0);

    do_reset(); cfg_ocp_latch = 1;
    for (int k = 0; k < 5; k++) begin
      ocp_flag = 1; tick(1); ocp_flag = 0;
      wait_fault(0); tick(2);
    end
    check("R6 separated events no latch", latched, 0);

    do_reset();
    ovp_flag = 1; #1;
    check("R7 disabled ovp ignored", bridge_cmd, 0);
    check("R7 disabled no fault", fault_flag, 0);
    cfg_ovp_en = 1; #1;
    check("R7 ovp hiz", bridge_cmd, 1);
    check("R7 ovp fault", fault_flag, 1);
    ovp_flag = 0; #1;
    check("R7 ovp release", bridge_cmd, 0);

    tick(1); tsd_set = 1; tick(1); tsd_set = 0;
    check("R8 tsd hiz", bridge_cmd, 1);
    tick(5);
    check("R8 tsd held", fault_flag, 1);
    tsd_clr = 1; tick(1); tsd_clr = 0;
    check("R8 tsd cleared", bridge_cmd, 0);

    clamp_flag = 1; #1;
    check("R10 clamp hs off", bridge_cmd, 2);
    cfg_clamp_dis = 1; #1;
    check("R10 clamp disabled", bridge_cmd, 0);
    clamp_flag = 0; cfg_clamp_dis = 0;

    do_reset(); cfg_ovp_en = 1;
    for (int i = 0; i < 32; i++) begin
      int t, l, u, o, c, ec;
      t = i & 1; l = (i >> 1) & 1; u = (i >> 2) & 1; o = (i >> 3) & 1; c = (i >> 4) & 1;
      tsd_set = t[0]; tsd_clr = ~t[0]; pwm_start = 1; ilim_flag = l[0];
      uvlo_flag = 0; ovp_flag = 0; clamp_flag = 0;
      tick(1);
      tsd_set = 0; tsd_clr = 0; pwm_start = 0; ilim_flag = 0;
      uvlo_flag = u[0]; ovp_flag = o[0]; clamp_flag = c[0]; #1;
      ec = (u | t | o) ? 1 : l ? 3 : c ? 2 : 0;
      check("R11 priority cmd", bridge_cmd, ec);
      check("R11 fault flag", fault_flag, t | o);
      tick(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule